// File: doc/BRIEF.md
# MESI Snooping Cache Controller

This block is the coherence controller of one core's private cache on a shared, single-transaction snooping bus. The cache is direct-mapped and write-back, with one data word per line. The core sends read and write requests over a valid/ready stream. The controller either answers from its own lines or first wins the bus and runs one or more coherence transactions: a plain read, a read-for-ownership, an upgrade that invalidates other copies, or a writeback of a dirty victim.

At the same time the controller watches the transactions that other cores put on the bus. It compares each snooped address against its own tags. It raises a shared indication on a hit and supplies the line's data when it holds the only up-to-date copy. It then drops its own line to Shared or to Invalid, according to the kind of transaction.

Addresses are word addresses. The low `log2(SETS)` bits select the set and the remaining upper bits form the tag. Back-pressure on the request stream:
- `req_ready` is high only when the controller is idle and no snoop is present in that cycle.
- One request is outstanding at a time.

Back-pressure on the response stream:
- `resp_valid` stays high, with `resp_rdata` unchanged, until the core raises `resp_ready`.

Top module: `mesi_snoop_cache`

## Requirements
- R1: After reset every line is Invalid, `req_ready` is high, and both `bus_req` and `resp_valid` are low.
- R2: A read that hits a valid line, and a write that hits a Modified or Exclusive line, completes without raising `bus_req`. A write to an Exclusive line leaves it Modified, which a later snoop observes as a data supply.
- R3: A write that hits a Shared line raises `bus_req` with `bus_cmd` = 2 (upgrade) and the request's address. Once granted, the line becomes Modified and the write then completes.
- R4: A read miss requests `bus_cmd` = 0 (read). The line is filled from `bus_rdata` as Exclusive when `bus_shared_in` is low in the grant cycle, and as Shared when it is high.
- R5: A write miss requests `bus_cmd` = 1 (read-for-ownership). The line is filled as Modified, and the write data then replaces the word.
- R6: A miss whose victim line is Modified first requests `bus_cmd` = 3 (writeback), with `bus_addr` = {victim tag, index} and `bus_wdata` = the victim data, and only then requests the fill. A clean victim is dropped with no writeback.
- R7: A snooped read (`snp_cmd` = 0) that hits a valid line raises `snp_shared`. If the line is Modified, it also raises `snp_supply` with the line in `snp_data`. The line ends up Shared.
- R8: A snooped read-for-ownership (1) that hits raises `snp_shared`, supplies the data if the line is Modified, and invalidates the line. A snooped upgrade (2) that hits raises `snp_shared` and invalidates the line. A snooped writeback (3) changes nothing and raises no snoop output.
- R9: In a cycle with `snp_valid` high, `req_ready` is low and the local request makes no progress.
- R10: `bus_req` stays high until granted. If a snoop changes the line while the request waits, the command is re-chosen, so a pending upgrade becomes a read-for-ownership.
- R11: `resp_valid` holds with stable `resp_rdata` until `resp_ready`. A write returns its own data, and a read returns the line word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core request valid |
| req_ready | output | 1 | Controller accepts a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address of the request |
| req_wdata | input | DATA_W | Write data |
| resp_valid | output | 1 | Response valid |
| resp_ready | input | 1 | Core accepts the response |
| resp_rdata | output | DATA_W | Read data, or the written data for a write |
| bus_req | output | 1 | Bus request for a transaction |
| bus_gnt | input | 1 | Bus grant; the transaction occurs in the cycle with both high |
| bus_cmd | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade, 3 writeback |
| bus_addr | output | ADDR_W | Transaction address |
| bus_wdata | output | DATA_W | Writeback data |
| bus_rdata | input | DATA_W | Fill data in the grant cycle |
| bus_shared_in | input | 1 | Another cache holds the line (read fills) |
| snp_valid | input | 1 | Another core's transaction is on the bus |
| snp_cmd | input | 2 | Snooped command, same encoding as bus_cmd |
| snp_addr | input | ADDR_W | Snooped address |
| snp_shared | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies dirty data |
| snp_data | output | DATA_W | Supplied data, zero when not supplying |

## Verification
The bench attacks the transitions where a single wrong state would be invisible until later:
- It silently upgrades an Exclusive line and then snoops it. A design that skipped the move to Modified would fail to supply the data.
- It forces an eviction of a dirty line. A design that filled before writing back would lose the data or show the wrong `bus_addr`.
- It holds off the grant of a pending upgrade while another core's upgrade invalidates the same line. A design that latched its command would upgrade a line it no longer owns instead of issuing a read-for-ownership.
- It collides a request with a snoop in the same cycle.
- It stalls the response stream.

// File: rtl/coh_pkg.sv
package coh_pkg;
  typedef enum logic [1:0] {
    LN_INV = 2'd0,
    LN_SHR = 2'd1,
    LN_EXC = 2'd2,
    LN_MOD = 2'd3
  } line_st_e;

  typedef enum logic [1:0] {
    BUS_RD  = 2'd0,
    BUS_RDX = 2'd1,
    BUS_UPG = 2'd2,
    BUS_WB  = 2'd3
  } bus_op_e;
endpackage

// File: rtl/coh_line_store.sv
module coh_line_store
  import coh_pkg::*;
#(
  parameter int SETS   = 8,
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(SETS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pa_idx,
  output line_st_e          pa_st,
  output logic [TAG_W-1:0]  pa_tag,
  output logic [DATA_W-1:0] pa_data,
  input  logic [IDX_W-1:0]  pb_idx,
  output line_st_e          pb_st,
  output logic [TAG_W-1:0]  pb_tag,
  output logic [DATA_W-1:0] pb_data,
  input  logic              wr_st_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  line_st_e          wr_st,
  input  logic              wr_tag_en,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic              wr_data_en,
  input  logic [DATA_W-1:0] wr_data
);
  line_st_e          st_q  [SETS];
  logic [TAG_W-1:0]  tag_q [SETS];
  logic [DATA_W-1:0] dat_q [SETS];

  // State bits carry reset; tag and data are qualified by state.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < SETS; i++) st_q[i] <= LN_INV;
    end else if (wr_st_en) begin
      st_q[wr_idx] <= wr_st;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_tag_en)  tag_q[wr_idx] <= wr_tag;
    if (wr_data_en) dat_q[wr_idx] <= wr_data;
  end

  assign pa_st   = st_q[pa_idx];
  assign pa_tag  = tag_q[pa_idx];
  assign pa_data = dat_q[pa_idx];
  assign pb_st   = st_q[pb_idx];
  assign pb_tag  = tag_q[pb_idx];
  assign pb_data = dat_q[pb_idx];
endmodule

// File: rtl/coh_snoop_resp.sv
module coh_snoop_resp
  import coh_pkg::*;
#(
  parameter int TAG_W  = 9,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  bus_op_e           snp_op,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_st_e          ln_st,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              shared_o,
  output logic              supply_o,
  output logic [DATA_W-1:0] data_o,
  output logic              upd_en,
  output line_st_e          upd_st
);
  logic hit;
  assign hit = snp_valid && (ln_st != LN_INV) && (ln_tag == snp_tag);

  always_comb begin
    shared_o = 1'b0;
    supply_o = 1'b0;
    upd_en   = 1'b0;
    upd_st   = LN_INV;
    unique case (snp_op)
      BUS_RD: begin
        shared_o = hit;
        supply_o = hit && (ln_st == LN_MOD);
        upd_en   = hit;
        upd_st   = LN_SHR;
      end
      BUS_RDX: begin
        shared_o = hit;
        supply_o = hit && (ln_st == LN_MOD);
        upd_en   = hit;
      end
      BUS_UPG: begin
        shared_o = hit;
        upd_en   = hit;
      end
      default: ;
    endcase
  end

  assign data_o = supply_o ? ln_data : '0;
endmodule

// File: rtl/coh_local_engine.sv
module coh_local_engine
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_rdata,
  input  logic              snp_valid,
  output logic              bus_req,
  input  logic              bus_gnt,
  output bus_op_e           bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  output logic [IDX_W-1:0]  a_idx,
  input  line_st_e          a_st,
  input  logic [TAG_W-1:0]  a_tag,
  input  logic [DATA_W-1:0] a_data,
  output logic              ws_en,
  output line_st_e          ws_st,
  output logic              wt_en,
  output logic [TAG_W-1:0]  wt_tag,
  output logic              wd_en,
  output logic [DATA_W-1:0] wd_data
);
  typedef enum logic [1:0] {PH_IDLE, PH_WORK, PH_RESP} phase_e;

  phase_e            ph_q;
  logic              op_wr_q;
  logic [ADDR_W-1:0] op_addr_q;
  logic [DATA_W-1:0] op_wdata_q;
  logic [DATA_W-1:0] rsp_q;
  logic [IDX_W-1:0]  op_idx;
  logic [TAG_W-1:0]  op_tag;
  logic              line_hit;
  logic              can_finish;
  logic              finish;
  logic              take_gnt;

  assign op_idx = op_addr_q[IDX_W-1:0];
  assign op_tag = op_addr_q[ADDR_W-1:IDX_W];
  assign a_idx  = op_idx;

  assign line_hit   = (a_st != LN_INV) && (a_tag == op_tag);
  assign can_finish = line_hit && (!op_wr_q || a_st == LN_EXC || a_st == LN_MOD);
  assign bus_req    = (ph_q == PH_WORK) && !can_finish;
  // Snoops own the tag port for the cycle; local work waits.
  assign finish     = (ph_q == PH_WORK) && can_finish && !snp_valid;
  assign take_gnt   = bus_req && bus_gnt && !snp_valid;

  // Command chosen from the present line every cycle, so snoops that land
  // while waiting for the grant are honoured.
  always_comb begin
    if (line_hit) begin
      bus_cmd  = BUS_UPG;
      bus_addr = op_addr_q;
    end else if (a_st == LN_MOD) begin
      bus_cmd  = BUS_WB;
      bus_addr = {a_tag, op_idx};
    end else begin
      bus_cmd  = op_wr_q ? BUS_RDX : BUS_RD;
      bus_addr = op_addr_q;
    end
  end
  assign bus_wdata = a_data;

  always_comb begin
    ws_en   = 1'b0;
    ws_st   = LN_INV;
    wt_en   = 1'b0;
    wt_tag  = op_tag;
    wd_en   = 1'b0;
    wd_data = op_wdata_q;
    if (finish && op_wr_q) begin
      ws_en = 1'b1;
      ws_st = LN_MOD;
      wd_en = 1'b1;
    end else if (take_gnt) begin
      unique case (bus_cmd)
        BUS_UPG: begin
          ws_en = 1'b1;
          ws_st = LN_MOD;
        end
        BUS_WB: begin
          ws_en = 1'b1;
          ws_st = LN_INV;
        end
        BUS_RD: begin
          ws_en   = 1'b1;
          ws_st   = bus_shared_in ? LN_SHR : LN_EXC;
          wt_en   = 1'b1;
          wd_en   = 1'b1;
          wd_data = bus_rdata;
        end
        default: begin
          ws_en   = 1'b1;
          ws_st   = LN_MOD;
          wt_en   = 1'b1;
          wd_en   = 1'b1;
          wd_data = bus_rdata;
        end
      endcase
    end
  end

  assign req_ready  = (ph_q == PH_IDLE) && !snp_valid;
  assign resp_valid = (ph_q == PH_RESP);
  assign resp_rdata = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q       <= PH_IDLE;
      op_wr_q    <= 1'b0;
      op_addr_q  <= '0;
      op_wdata_q <= '0;
      rsp_q      <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (req_valid && req_ready) begin
          op_wr_q    <= req_write;
          op_addr_q  <= req_addr;
          op_wdata_q <= req_wdata;
          ph_q       <= PH_WORK;
        end
        PH_WORK: if (finish) begin
          rsp_q <= op_wr_q ? op_wdata_q : a_data;
          ph_q  <= PH_RESP;
        end
        default: if (resp_ready) ph_q <= PH_IDLE;
      endcase
    end
  end

  assert_resp_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (resp_valid && !resp_ready) |=> (resp_valid && $stable(resp_rdata)))
    else $error("response dropped or changed before handshake");

  assert_bus_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt) |=> bus_req)
    else $error("bus request withdrawn before grant");

  assert_upgrade_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == BUS_UPG) |=> (a_st == LN_MOD))
    else $error("granted upgrade did not leave line Modified");

  assert_fill_shared_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && bus_gnt && !snp_valid && bus_cmd == BUS_RD && bus_shared_in) |=> (a_st == LN_SHR))
    else $error("shared read fill not held Shared");
endmodule

// File: rtl/mesi_snoop_cache.sv
module mesi_snoop_cache
  import coh_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int SETS   = 8,
  localparam int IDX_W = $clog2(SETS),
  localparam int TAG_W = ADDR_W - IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              resp_valid,
  input  logic              resp_ready,
  output logic [DATA_W-1:0] resp_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_shared_in,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_shared,
  output logic              snp_supply,
  output logic [DATA_W-1:0] snp_data
);
  logic [IDX_W-1:0]  a_idx;
  line_st_e          a_st, b_st;
  logic [TAG_W-1:0]  a_tag, b_tag;
  logic [DATA_W-1:0] a_data, b_data;
  bus_op_e           eng_cmd;
  logic              e_ws_en, e_wt_en, e_wd_en;
  line_st_e          e_ws_st;
  logic [TAG_W-1:0]  e_wt_tag;
  logic [DATA_W-1:0] e_wd_data;
  logic              s_upd_en;
  line_st_e          s_upd_st;
  logic [IDX_W-1:0]  snp_idx;
  logic              w_st_en, w_tag_en, w_data_en;
  logic [IDX_W-1:0]  w_idx;
  line_st_e          w_st;

  assign snp_idx = snp_addr[IDX_W-1:0];
  assign bus_cmd = eng_cmd;

  coh_local_engine #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETS(SETS)) u_eng (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
    .snp_valid(snp_valid),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(eng_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .a_idx(a_idx), .a_st(a_st), .a_tag(a_tag), .a_data(a_data),
    .ws_en(e_ws_en), .ws_st(e_ws_st), .wt_en(e_wt_en), .wt_tag(e_wt_tag),
    .wd_en(e_wd_en), .wd_data(e_wd_data)
  );

  coh_snoop_resp #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snp (
    .snp_valid(snp_valid), .snp_op(bus_op_e'(snp_cmd)),
    .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .ln_st(b_st), .ln_tag(b_tag), .ln_data(b_data),
    .shared_o(snp_shared), .supply_o(snp_supply), .data_o(snp_data),
    .upd_en(s_upd_en), .upd_st(s_upd_st)
  );

  // Single write port: the engine is stalled whenever a snoop is present.
  always_comb begin
    if (s_upd_en) begin
      w_st_en   = 1'b1;
      w_idx     = snp_idx;
      w_st      = s_upd_st;
      w_tag_en  = 1'b0;
      w_data_en = 1'b0;
    end else begin
      w_st_en   = e_ws_en;
      w_idx     = a_idx;
      w_st      = e_ws_st;
      w_tag_en  = e_wt_en;
      w_data_en = e_wd_en;
    end
  end

  coh_line_store #(.SETS(SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .pa_idx(a_idx), .pa_st(a_st), .pa_tag(a_tag), .pa_data(a_data),
    .pb_idx(snp_idx), .pb_st(b_st), .pb_tag(b_tag), .pb_data(b_data),
    .wr_st_en(w_st_en), .wr_idx(w_idx), .wr_st(w_st),
    .wr_tag_en(w_tag_en), .wr_tag(e_wt_tag),
    .wr_data_en(w_data_en), .wr_data(e_wd_data)
  );

  assert_snoop_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
    snp_valid |-> !req_ready)
    else $error("request accepted during a snoop");
endmodule

// File: tb/mesi_snoop_cache_test.sv
`timescale 1ns/1ps
module mesi_snoop_cache_test;
  localparam int AW = 12;
  localparam int DW = 16;
  localparam int NS = 8;

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0, req_ready, req_write = 0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic resp_valid, resp_ready = 1;
  logic [DW-1:0] resp_rdata;
  logic bus_req, bus_gnt = 0;
  logic [1:0] bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata, bus_rdata;
  logic bus_shared_in = 0;
  logic snp_valid = 0;
  logic [1:0] snp_cmd = 0;
  logic [AW-1:0] snp_addr = '0;
  logic snp_shared, snp_supply;
  logic [DW-1:0] snp_data;

  int salt = 0;
  assign bus_rdata = DW'(((32'(bus_addr) * 7) + 32'h100) ^ salt);

  mesi_snoop_cache uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .resp_valid(resp_valid), .resp_ready(resp_ready), .resp_rdata(resp_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_shared_in(bus_shared_in),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_shared(snp_shared), .snp_supply(snp_supply), .snp_data(snp_data)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  string cur = "R1";

  // Drive values applied at the next negedge.
  bit d_req_valid = 0, d_wr = 0, d_resp_ready = 1, d_shared = 0;
  int d_addr = 0, d_wdata = 0;
  bit d_snp_valid = 0;
  int d_snp_cmd = 0, d_snp_addr = 0;
  int gnt_delay = 0, gwait = 0;

  // Behavioural model: 0 I, 1 S, 2 E, 3 M
  int mst[NS], mtag[NS], mdat[NS];
  int ph = 0;
  bit o_wr = 0;
  int o_addr = 0, o_wdata = 0, o_resp = 0;

  function automatic int memval(int a);
    return (((a * 7) + 'h100) ^ salt) & 'hFFFF;
  endfunction

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  task automatic cycle();
    int oi, ot, si, st, cmd, baddr, ph_old;
    bit lhit, fin, need, shit, sup;
    @(negedge clk);
    req_valid = d_req_valid; req_write = d_wr;
    req_addr = AW'(d_addr); req_wdata = DW'(d_wdata);
    resp_ready = d_resp_ready; bus_shared_in = d_shared;
    snp_valid = d_snp_valid; snp_cmd = 2'(d_snp_cmd); snp_addr = AW'(d_snp_addr);
    oi = o_addr % NS; ot = o_addr / NS;
    lhit = (mst[oi] != 0) && (mtag[oi] == ot);
    fin  = (ph == 1) && lhit && (!o_wr || mst[oi] >= 2);
    need = (ph == 1) && !fin;
    if (lhit) begin cmd = 2; baddr = o_addr; end
    else if (mst[oi] == 3) begin cmd = 3; baddr = mtag[oi] * NS + oi; end
    else begin cmd = o_wr ? 1 : 0; baddr = o_addr; end
    bus_gnt = need && (gwait >= gnt_delay) && !d_snp_valid;
    si = d_snp_addr % NS; st = d_snp_addr / NS;
    shit = d_snp_valid && d_snp_cmd != 3 && mst[si] != 0 && mtag[si] == st;
    sup  = shit && mst[si] == 3 && d_snp_cmd <= 1;
    #1;
    check({cur, " req_ready"}, int'(req_ready), int'(ph == 0 && !d_snp_valid));
    check({cur, " resp_valid"}, int'(resp_valid), int'(ph == 2));
    if (ph == 2) check({cur, " resp_rdata"}, int'(resp_rdata), o_resp);
    check({cur, " bus_req"}, int'(bus_req), int'(need));
    if (need) begin
      check({cur, " bus_cmd"}, int'(bus_cmd), cmd);
      check({cur, " bus_addr"}, int'(bus_addr), baddr);
      if (cmd == 3) check({cur, " bus_wdata"}, int'(bus_wdata), mdat[oi]);
    end
    check({cur, " snp_shared"}, int'(snp_shared), int'(shit));
    check({cur, " snp_supply"}, int'(snp_supply), int'(sup));
    check({cur, " snp_data"}, int'(snp_data), sup ? mdat[si] : 0);
    // commit
    ph_old = ph;
    if (need && !bus_gnt) gwait++;
    if (bus_gnt) gwait = 0;
    if (d_snp_valid) begin
      if (shit) mst[si] = (d_snp_cmd == 0) ? 1 : 0;
    end else if (ph_old == 1) begin
      if (fin) begin
        if (o_wr) begin mst[oi] = 3; mdat[oi] = o_wdata; o_resp = o_wdata; end
        else o_resp = mdat[oi];
        ph = 2;
      end else if (bus_gnt) begin
        case (cmd)
          2: mst[oi] = 3;
          3: mst[oi] = 0;
          0: begin mtag[oi] = ot; mdat[oi] = memval(o_addr); mst[oi] = d_shared ? 1 : 2; end
          default: begin mtag[oi] = ot; mdat[oi] = memval(o_addr); mst[oi] = 3; end
        endcase
      end
    end
    if (ph_old == 0 && !d_snp_valid && d_req_valid) begin
      o_wr = d_wr; o_addr = d_addr; o_wdata = d_wdata & 'hFFFF; ph = 1;
    end
    if (ph_old == 2 && d_resp_ready) ph = 0;
    @(posedge clk);
    #1;
  endtask

  task automatic run_req(input int hold);
    int held = 0;
    for (int n = 0; n < 80; n++) begin
      d_resp_ready = !(ph == 2 && held < hold);
      if (ph == 2 && held < hold) held++;
      cycle();
      if (ph != 0) d_req_valid = 0;
      if (!d_req_valid && ph == 0) break;
    end
    d_resp_ready = 1;
  endtask

  task automatic issue(input bit wr, input int addr, input int wdata, input int hold);
    d_wr = wr; d_addr = addr; d_wdata = wdata; d_req_valid = 1;
    run_req(hold);
  endtask

  task automatic snoop(input int cmd, input int addr);
    d_snp_valid = 1; d_snp_cmd = cmd; d_snp_addr = addr;
    cycle();
    d_snp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog R1: actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < NS; i++) begin mst[i] = 0; mtag[i] = 0; mdat[i] = 0; end
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1: reset state
    check("R1 req_ready", int'(req_ready), 1);
    check("R1 bus_req", int'(bus_req), 0);
    check("R1 resp_valid", int'(resp_valid), 0);
    cur = "R1"; snoop(0, 'h010); snoop(1, 'h123);

    // R4: read miss, exclusive fill, then R7 clean snoop read
    cur = "R4"; salt = 'h5a; issue(0, 'h010, 0, 0);
    cur = "R7"; snoop(0, 'h010);
    // R3: write to Shared line with delayed grant (R10 hold)
    cur = "R3"; gnt_delay = 3; issue(1, 'h010, 'hBEEF, 0); gnt_delay = 0;
    cur = "R7"; snoop(0, 'h010); snoop(0, 'h010);

    // R2: silent upgrade of Exclusive, then hits
    cur = "R2"; issue(0, 'h021, 0, 0); issue(1, 'h021, 'h1234, 0);
    issue(0, 'h021, 0, 0); snoop(0, 'h021);
    // R4 shared fill
    cur = "R4"; d_shared = 1; issue(0, 'h05B, 0, 0); d_shared = 0; issue(0, 'h05B, 0, 0);

    // R5: write miss
    cur = "R5"; issue(1, 'h032, 'hCAFE, 0); issue(0, 'h032, 0, 0);
    // R6: dirty victim writeback, then clean victim silent
    cur = "R6"; salt = 'h3c; issue(0, 'h03A, 0, 0); issue(0, 'h042, 0, 0);

    // R8: snoop RDX on Modified, upgrade on Shared, writeback no effect
    cur = "R8"; issue(1, 'h024, 'h7777, 0);
    snoop(3, 'h024); snoop(1, 'h024); snoop(0, 'h024);
    d_shared = 1; issue(0, 'h045, 0, 0); d_shared = 0;
    snoop(2, 'h045); snoop(0, 'h045);

    // R9: request and snoop collide
    cur = "R9"; issue(0, 'h016, 0, 0);
    d_wr = 0; d_addr = 'h016; d_req_valid = 1;
    d_snp_valid = 1; d_snp_cmd = 0; d_snp_addr = 'h016;
    cycle();
    check("R9 no accept", ph, 0);
    d_snp_valid = 0;
    run_req(0);

    // R10: pending upgrade overtaken by another core's upgrade
    cur = "R10"; d_shared = 1; issue(0, 'h027, 0, 0); d_shared = 0;
    gnt_delay = 100;
    d_wr = 1; d_addr = 'h027; d_wdata = 'h4242; d_req_valid = 1;
    cycle(); d_req_valid = 0;
    cycle(); cycle();
    snoop(2, 'h027);
    gnt_delay = 0;
    run_req(0);
    snoop(0, 'h027);

    // R11: response back-pressure
    cur = "R11"; issue(0, 'h032, 0, 4); issue(1, 'h010, 'h0F0F, 3);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule